// File: doc/BRIEF.md
# Dual-Direction AES Byte Substitution Unit

This unit substitutes a single byte using either the forward AES substitution box or its inverse. A one-bit direction input selects which. Both directions share one GF(2^8) multiplicative-inverse lookup built over the field polynomial x^8+x^4+x^3+x+1. For the forward direction, the raw byte is inverted and then passed through the affine map with constant 0x63. For the inverse direction, the byte first passes through the inverse affine map with constant 0x05 and is then inverted. In both cases the field inverse of 0x00 is taken to be 0x00.

The inverse lookup is not one 256-entry table. It is split into a parameterised number of equal banks, eight by default, each holding 32 entries. All banks are read with the low address bits, and the high address bits pick which bank output is used. Bank contents are computed when the design is elaborated. By default the result passes through an output register with a synchronous active-high reset, which gives one cycle of latency. A new byte and a new direction can be presented on every clock. A wider datapath is built by placing several of these units side by side.

Top module: `sbox_dual`

## Requirements
- R1: With `mode`=0 the result equals the forward AES substitution of `din`: 0x53 gives 0xED and 0x01 gives 0x7C.
- R2: With `mode`=1 the result equals the inverse AES substitution of `din`: 0xED gives 0x53 and 0x7C gives 0x01.
- R3: The inverse stage maps 0x00 to 0x00, so forward 0x00 gives 0x63 and inverse 0x63 gives 0x00.
- R4: Over all 256 byte values, the inverse substitution applied to the forward result returns the original byte, and the forward substitution applied to the inverse result also returns the original byte.
- R5: No output equals its own input, and no output equals the bitwise complement of its input, in either direction.
- R6: With `OUT_REG`=1, the result for the `din` and `mode` sampled at a rising edge appears on `dout` right after that edge and holds for exactly one cycle.
- R7: While `rst` is high at a rising edge, `dout` becomes 0x00.
- R8: `mode` may change on every cycle, and each cycle's result follows that cycle's own `mode` with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset, clears `dout` |
| mode | input | 1 | Direction select: 0 = forward substitution, 1 = inverse substitution |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte, registered when `OUT_REG`=1 |

## Verification
The checker assumes the output register is present. It also assumes that `din` and `mode` are known, two-valued values at every sampling edge outside reset, because every property compares `dout` against the `din` and `mode` of the previous edge. The bench meets this by always driving both inputs on the falling edge and never leaving them floating. This holds even while reset is asserted and during the final drain cycle. The stimulus covers every byte value in both directions, plus an alternating-direction sequence, so the fixed-point and zero-mapping properties are exercised across all eight banks of the inverse table.

// File: rtl/sbox_dual_pkg.sv
package sbox_dual_pkg;

  localparam int BYTE_W   = 8;
  localparam int FIELD_SZ = 1 << BYTE_W;

  typedef enum logic {
    SUB_FWD = 1'b0,
    SUB_INV = 1'b1
  } sub_dir_e;

  // Multiply two field elements; red holds the low byte of the reduction polynomial.
  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b,
                                               input logic [BYTE_W-1:0] red);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? red : '0);
    end
    return acc;
  endfunction

  // Field inverse as a^(2^8-2); zero maps to zero by this exponentiation.
  function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] red);
    logic [BYTE_W-1:0] res;
    logic [BYTE_W-1:0] pw;
    int unsigned       ex;
    res = 8'h01;
    pw  = a;
    ex  = FIELD_SZ - 2;
    for (int i = 0; i < BYTE_W; i++) begin
      if (ex[i]) res = gf_mul(res, pw, red);
      pw = gf_mul(pw, pw, red);
    end
    return res;
  endfunction

endpackage

// File: rtl/sbox_affine.sv
module sbox_affine
  import sbox_dual_pkg::*;
#(
  parameter bit                INVERSE = 1'b0,
  parameter logic [BYTE_W-1:0] CONST_V = 8'h63
) (
  input  logic [BYTE_W-1:0] x,
  output logic [BYTE_W-1:0] y
);

  genvar i;
  generate
    for (i = 0; i < BYTE_W; i++) begin : g_bit
      if (INVERSE) begin : g_back
        assign y[i] = x[(i + 2) % BYTE_W] ^ x[(i + 5) % BYTE_W] ^
                      x[(i + 7) % BYTE_W] ^ CONST_V[i];
      end else begin : g_fwd
        assign y[i] = x[i] ^ x[(i + 4) % BYTE_W] ^ x[(i + 5) % BYTE_W] ^
                      x[(i + 6) % BYTE_W] ^ x[(i + 7) % BYTE_W] ^ CONST_V[i];
      end
    end
  endgenerate

endmodule

// File: rtl/sbox_inv_bank.sv
module sbox_inv_bank
  import sbox_dual_pkg::*;
#(
  parameter int                BANKS   = 8,
  parameter logic [BYTE_W-1:0] RED_POLY = 8'h1B
) (
  input  logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] data
);

  localparam int DEPTH = FIELD_SZ / BANKS;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SEL_W = $clog2(BANKS);
  localparam int ROM_W = DEPTH * BYTE_W;

  function automatic logic [ROM_W-1:0] fill_bank(input int bank);
    logic [ROM_W-1:0] img;
    img = '0;
    for (int e = 0; e < DEPTH; e++) begin
      img[e*BYTE_W +: BYTE_W] = gf_inv(BYTE_W'(bank * DEPTH + e), RED_POLY);
    end
    return img;
  endfunction

  logic [IDX_W-1:0]  idx;
  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] bank_q [BANKS];

  assign idx = addr[IDX_W-1:0];
  assign sel = addr[BYTE_W-1 -: SEL_W];

  genvar g;
  generate
    for (g = 0; g < BANKS; g++) begin : g_bank
      localparam logic [ROM_W-1:0] IMG = fill_bank(g);
      assign bank_q[g] = IMG[idx*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign data = bank_q[sel];

endmodule

// File: rtl/sbox_dual.sv
module sbox_dual
  import sbox_dual_pkg::*;
#(
  parameter bit                OUT_REG  = 1'b1,
  parameter int                BANKS    = 8,
  parameter logic [BYTE_W-1:0] RED_POLY = 8'h1B,
  parameter logic [BYTE_W-1:0] FWD_C    = 8'h63,
  parameter logic [BYTE_W-1:0] INV_C    = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  sub_dir_e          dir;
  logic [BYTE_W-1:0] pre_aff;
  logic [BYTE_W-1:0] tbl_in;
  logic [BYTE_W-1:0] tbl_out;
  logic [BYTE_W-1:0] post_aff;
  logic [BYTE_W-1:0] result;

  assign dir = sub_dir_e'(mode);

  sbox_affine #(.INVERSE(1'b1), .CONST_V(INV_C)) u_pre (
    .x(din),
    .y(pre_aff)
  );

  assign tbl_in = (dir == SUB_INV) ? pre_aff : din;

  sbox_inv_bank #(.BANKS(BANKS), .RED_POLY(RED_POLY)) u_inv (
    .addr(tbl_in),
    .data(tbl_out)
  );

  sbox_affine #(.INVERSE(1'b0), .CONST_V(FWD_C)) u_post (
    .x(tbl_out),
    .y(post_aff)
  );

  assign result = (dir == SUB_INV) ? tbl_out : post_aff;

  generate
    if (OUT_REG) begin : g_reg
      logic [BYTE_W-1:0] dout_q;
      always_ff @(posedge clk) begin
        if (rst) dout_q <= '0;
        else     dout_q <= result;
      end
      assign dout = dout_q;
    end else begin : g_comb
      assign dout = result;
    end
  endgenerate

endmodule

// File: rtl/sbox_dual_chk.sv
module sbox_dual_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       mode,
  input logic [7:0] din,
  input logic [7:0] dout
);

  generate
    if (OUT_REG) begin : g_chk
      // R7
      reset_clear_chk: assert property (@(posedge clk)
        rst |=> dout == 8'h00);

      // R1
      fwd_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode && din == 8'h53) |=> dout == 8'hED);

      // R2
      inv_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (mode && din == 8'hED) |=> dout == 8'h53);

      // R3
      zero_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode && din == 8'h00) |=> dout == 8'h63);

      // R3
      zero_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (mode && din == 8'h63) |=> dout == 8'h00);

      // R5
      no_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> dout != $past(din));

      // R5
      no_compl_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> dout != ~$past(din));
    end
  endgenerate

endmodule

bind sbox_dual sbox_dual_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk (clk),
  .rst (rst),
  .mode(mode),
  .din (din),
  .dout(dout)
);

// File: tb/sbox_dual_tb.sv
module sbox_dual_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  int         idx_q [$];
  logic [7:0] fwd_tab [256];
  logic [7:0] obs [256];

  always #4 clk = ~clk;  // 125 MHz

  sbox_dual u_dut (
    .clk (clk),
    .rst (rst),
    .mode(mode),
    .din (din),
    .dout(dout)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected <= 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
    int acc = 0;
    int x = a;
    for (int k = 0; k < 8; k++) begin
      if ((b >> k) & 1) acc = acc ^ x;
      x = x << 1;
      if (x & 256) x = x ^ 283;
    end
    return acc[7:0];
  endfunction

  function automatic logic [7:0] rinv(input logic [7:0] a);
    for (int y = 1; y < 256; y++)
      if (rmul(a, y[7:0]) == 8'h01) return y[7:0];
    return 8'h00;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] rfwd(input logic [7:0] a);
    logic [7:0] b = rinv(a);
    return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] rback(input logic [7:0] a);
    for (int x = 0; x < 256; x++)
      if (fwd_tab[x] == a) return x[7:0];
    return 8'hxx;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic pop_one();
    if (exp_q.size() > 0) begin
      int ix = idx_q.pop_front();
      check(tag_q.pop_front(), dout, exp_q.pop_front());
      if (ix >= 0) obs[ix] = dout;
    end
  endtask

  task automatic step(input logic m, input logic [7:0] d, input logic [7:0] e,
                      input string tag, input int ix);
    @(negedge clk);
    pop_one();
    mode = m;
    din  = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    idx_q.push_back(ix);
  endtask

  task automatic drain();
    @(negedge clk);
    pop_one();
  endtask

  initial begin
    int fixed_hits;
    logic [7:0] lf;
    for (int x = 0; x < 256; x++) fwd_tab[x] = rfwd(x[7:0]);

    // R7: reset with nonzero input
    din = 8'h5A;
    repeat (3) @(negedge clk);
    check("R7 reset", dout, 8'h00);
    rst = 1'b0;

    // R1 / R2 / R3 known pairs
    step(1'b0, 8'h53, 8'hED, "R1 fwd 53", -1);
    step(1'b0, 8'h01, 8'h7C, "R1 fwd 01", -1);
    step(1'b1, 8'hED, 8'h53, "R2 inv ED", -1);
    step(1'b1, 8'h7C, 8'h01, "R2 inv 7C", -1);
    step(1'b0, 8'h00, 8'h63, "R3 fwd 00", -1);
    step(1'b1, 8'h63, 8'h00, "R3 inv 63", -1);
    drain();

    // R6: one-cycle latency, value held exactly one cycle
    @(negedge clk);
    mode = 1'b0; din = 8'h53;
    @(negedge clk);
    check("R6 latency first", dout, 8'hED);
    mode = 1'b0; din = 8'h00;
    @(negedge clk);
    check("R6 next cycle", dout, 8'h63);

    // R1 forward sweep over all banks, recording outputs
    for (int x = 0; x < 256; x++) step(1'b0, x[7:0], fwd_tab[x], "R1 sweep", x);
    drain();
    fixed_hits = 0;
    for (int x = 0; x < 256; x++)
      if (obs[x] == x[7:0] || obs[x] == ~x[7:0]) fixed_hits++;
    checks++;
    if (fixed_hits != 0) begin
      fails++;
      $display("FAIL R5 fwd fixed points: actual=%0d expected=0", fixed_hits);
    end

    // R4 inverse of observed forward outputs
    for (int x = 0; x < 256; x++) step(1'b1, obs[x], x[7:0], "R4 inv(fwd)", -1);
    drain();

    // R2 inverse sweep, recording outputs
    for (int y = 0; y < 256; y++) step(1'b1, y[7:0], rback(y[7:0]), "R2 sweep", y);
    drain();
    fixed_hits = 0;
    for (int y = 0; y < 256; y++)
      if (obs[y] == y[7:0] || obs[y] == ~y[7:0]) fixed_hits++;
    checks++;
    if (fixed_hits != 0) begin
      fails++;
      $display("FAIL R5 inv fixed points: actual=%0d expected=0", fixed_hits);
    end

    // R4 forward of observed inverse outputs
    for (int y = 0; y < 256; y++) step(1'b0, obs[y], y[7:0], "R4 fwd(inv)", -1);
    drain();

    // R8 direction alternating every cycle
    lf = 8'hA7;
    for (int k = 0; k < 200; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (k % 2 == 0) step(1'b1, lf, rback(lf), "R8 alt inv", -1);
      else            step(1'b0, lf, fwd_tab[lf], "R8 alt fwd", -1);
    end
    drain();

    // R7 mid-stream reset
    @(negedge clk);
    mode = 1'b0; din = 8'h53; rst = 1'b1;
    @(negedge clk);
    check("R7 mid reset", dout, 8'h00);
    rst = 1'b0;
    step(1'b0, 8'h10, fwd_tab[8'h10], "R1 after reset", -1);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule